// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a small 16-bit load/store processor. It walks each instruction through a fetch, a single decode step and an opcode-specific execute sequence. Every cycle it drives bus gate enables, register load strobes, datapath mux selects, an ALU function code and memory strobes. The datapath, ALU, register file and memory sit outside the block. They see the sequencer only through these control outputs, and they return the opcode field of the instruction register and a branch-enable flag.

The outputs are Moore outputs: they depend only on the current state and on a small wait counter. Memory accesses stay in a wait phase for `MEM_HOLD` extra cycles so that a synchronous memory can answer. After reset the machine sits halted until Run is pulsed. A PAUSE instruction stops it until the Continue input is pressed and then released again.

Top module: `instr_sequencer`

## Requirements
- R1: Synchronous reset, taken in any state, returns the machine to the halted state with every output 0, and reset takes precedence over `run_i` in the same cycle. The machine stays halted, with all outputs 0, until a cycle with `run_i` high, after which fetch begins.
- R2: Fetch runs in four phases, followed by one decode cycle:
  - Address phase: `gate_pc`, `ld_mar` and `ld_pc` are high, with `pc_sel`=0 (increment).
  - Wait phase: `MEM_HOLD` cycles with only `mem_en` high.
  - Read phase: one cycle with `mem_en`, `ld_mdr` and `mdr_src`=1 (memory).
  - Instruction load: one cycle with `gate_mdr` and `ld_ir`.
  - Decode: one cycle with only `ld_ben` high, which dispatches on `opcode_i`.
- R3: In every cycle at most one of `gate_pc`, `gate_mdr`, `gate_alu` and `gate_addr` is high.
- R4: In every cycle at most one of `ld_mar`, `ld_mdr`, `ld_ir` and `ld_reg` is high.
- R5: Opcodes 0001 (add), 0101 (and) and 1001 (not) execute in one cycle with `gate_alu`, `ld_reg`, `ld_cc` and `dr_sel`=0 high. `alu_op` is 0, 1 and 2 respectively.
- R6: Opcode 0000 (branch) spends one cycle with all outputs 0 sampling `ben_i`. If `ben_i` is high, the next cycle asserts `ld_pc` with `pc_sel`=2 (adder), `addr1_sel`=0 (PC) and `addr2_sel`=2 (9-bit offset), then fetch follows. Otherwise fetch follows at once.
- R7: Opcode 1100 (jump) executes in one cycle with `ld_pc`, `pc_sel`=2, `addr1_sel`=1 (base register) and `addr2_sel`=0 (zero).
- R8: Opcode 0100 (subroutine call) runs two cycles:
  - First cycle: `gate_pc`, `ld_reg` and `dr_sel`=1 (R7).
  - Second cycle: `ld_pc` with `pc_sel`=2, `addr1_sel`=0 and `addr2_sel`=3 (11-bit offset).
- R9: Opcode 0110 (load) runs three phases:
  - Address: `gate_addr` and `ld_mar`, with `addr1_sel`=1 and `addr2_sel`=1 (6-bit offset).
  - Read: the same wait and read phases as fetch.
  - Write-back: one cycle of `gate_mdr`, `ld_reg` and `ld_cc`.
- R10: Opcode 0111 (store) runs three phases:
  - Address: the same address cycle as the load.
  - Data: one cycle of `gate_alu`, `ld_mdr`, `sr1_sel`=1 and `alu_op`=3 (pass), with `mdr_src`=0.
  - Write: `MEM_HOLD`+1 cycles of `mem_en` and `mem_we`.
- R11: Opcode 1101 (pause) waits with all outputs 0 until `cont_i` is high. It then waits, still with all outputs 0, until `cont_i` is low, and only then returns to fetch. A `cont_i` level that is already high on entry counts as a press.
- R12: Any opcode not listed above goes straight from decode to fetch.
- R13: `mem_we` is never high without `mem_en`. Mux selects and `alu_op` read 0 in every cycle that does not use them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Start execution from the halted state |
| cont_i | input | 1 | Resume from a pause (press then release) |
| opcode_i | input | 4 | Instruction register bits 15:12 |
| ben_i | input | 1 | Branch-enable flag from the datapath |
| gate_pc | output | 1 | Drive PC onto the bus |
| gate_mdr | output | 1 | Drive MDR onto the bus |
| gate_alu | output | 1 | Drive ALU result onto the bus |
| gate_addr | output | 1 | Drive address adder onto the bus |
| ld_mar | output | 1 | Load MAR |
| ld_mdr | output | 1 | Load MDR |
| ld_ir | output | 1 | Load instruction register |
| ld_reg | output | 1 | Write register file |
| ld_pc | output | 1 | Load PC |
| ld_cc | output | 1 | Load condition codes |
| ld_ben | output | 1 | Load branch-enable flag |
| pc_sel | output | 2 | PC source: 0 increment, 1 bus, 2 adder |
| addr1_sel | output | 1 | Adder base: 0 PC, 1 base register |
| addr2_sel | output | 2 | Adder offset: 0 zero, 1 six-bit, 2 nine-bit, 3 eleven-bit |
| dr_sel | output | 1 | Destination: 0 from instruction, 1 R7 |
| sr1_sel | output | 1 | Source 1: 0 bits 8:6, 1 bits 11:9 |
| alu_op | output | 2 | 0 add, 1 and, 2 not, 3 pass |
| mdr_src | output | 1 | MDR input: 0 bus, 1 memory |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |

## Verification
Two things can meet in one cycle. The first is reset with an activity already in progress: reset is raised in the middle of a fetch wait phase while `run_i` is also high. The bench expects the halted state on the next cycle, and expects it to hold until `run_i` returns after reset is released. The second is a Continue press with the entry into a pause: `cont_i` is already high when the pause state is reached. The bench expects the press to be honoured, and expects fetch to start only in the cycle after `cont_i` drops. A scoreboard compares the full control vector cycle by cycle against expectations built from the requirements, so an early or late return to fetch shows up as a mismatch.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [4:0] {
        S_HALT, S_FADDR, S_FREAD, S_FIR, S_DECODE,
        S_ADD, S_AND, S_NOT,
        S_BRCHK, S_BRTAKE, S_JMP,
        S_JSR_LINK, S_JSR_JUMP,
        S_LD_ADDR, S_LD_READ, S_LD_WB,
        S_ST_ADDR, S_ST_DATA, S_ST_WRITE,
        S_PAUSE_WAIT, S_PAUSE_REL
    } seq_state_e;

    localparam logic [3:0] OP_BR    = 4'b0000;
    localparam logic [3:0] OP_ADD   = 4'b0001;
    localparam logic [3:0] OP_JSR   = 4'b0100;
    localparam logic [3:0] OP_AND   = 4'b0101;
    localparam logic [3:0] OP_LDR   = 4'b0110;
    localparam logic [3:0] OP_STR   = 4'b0111;
    localparam logic [3:0] OP_NOT   = 4'b1001;
    localparam logic [3:0] OP_JMP   = 4'b1100;
    localparam logic [3:0] OP_PAUSE = 4'b1101;

    localparam logic [1:0] PCS_INC   = 2'd0;
    localparam logic [1:0] PCS_ADDER = 2'd2;
    localparam logic       A1_PC     = 1'b0;
    localparam logic       A1_BASE   = 1'b1;
    localparam logic [1:0] A2_ZERO   = 2'd0;
    localparam logic [1:0] A2_OFF6   = 2'd1;
    localparam logic [1:0] A2_OFF9   = 2'd2;
    localparam logic [1:0] A2_OFF11  = 2'd3;
    localparam logic [1:0] ALU_ADD   = 2'd0;
    localparam logic [1:0] ALU_AND   = 2'd1;
    localparam logic [1:0] ALU_NOT   = 2'd2;
    localparam logic [1:0] ALU_PASS  = 2'd3;

    typedef struct packed {
        logic       gate_pc;
        logic       gate_mdr;
        logic       gate_alu;
        logic       gate_addr;
        logic       ld_mar;
        logic       ld_mdr;
        logic       ld_ir;
        logic       ld_reg;
        logic       ld_pc;
        logic       ld_cc;
        logic       ld_ben;
        logic [1:0] pc_sel;
        logic       addr1_sel;
        logic [1:0] addr2_sel;
        logic       dr_sel;
        logic       sr1_sel;
        logic [1:0] alu_op;
        logic       mdr_src;
        logic       mem_en;
        logic       mem_we;
    } ctl_t;

    // States in which a memory access is held for the wait counter
    function automatic logic is_mem_state(seq_state_e s);
        return (s == S_FREAD) || (s == S_LD_READ) || (s == S_ST_WRITE);
    endfunction

endpackage

// File: rtl/seq_next.sv
module seq_next
    import seq_pkg::*;
#(
    parameter int MEM_HOLD = 2,
    parameter int CNT_W    = 2
) (
    input  seq_state_e       st,
    input  logic [CNT_W-1:0] cnt,
    input  logic [3:0]       opcode,
    input  logic             ben,
    input  logic             run,
    input  logic             cont,
    output seq_state_e       st_n,
    output logic [CNT_W-1:0] cnt_n,
    output logic             hold_last
);

    localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(MEM_HOLD);

    assign hold_last = (cnt == HOLD_END);

    always_comb begin
        cnt_n = (is_mem_state(st) && !hold_last) ? cnt + 1'b1 : '0;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            S_HALT:       if (run) st_n = S_FADDR;
            S_FADDR:      st_n = S_FREAD;
            S_FREAD:      if (hold_last) st_n = S_FIR;
            S_FIR:        st_n = S_DECODE;
            S_DECODE: begin
                case (opcode)
                    OP_ADD:   st_n = S_ADD;
                    OP_AND:   st_n = S_AND;
                    OP_NOT:   st_n = S_NOT;
                    OP_BR:    st_n = S_BRCHK;
                    OP_JMP:   st_n = S_JMP;
                    OP_JSR:   st_n = S_JSR_LINK;
                    OP_LDR:   st_n = S_LD_ADDR;
                    OP_STR:   st_n = S_ST_ADDR;
                    OP_PAUSE: st_n = S_PAUSE_WAIT;
                    default:  st_n = S_FADDR;
                endcase
            end
            S_BRCHK:      st_n = ben ? S_BRTAKE : S_FADDR;
            S_JSR_LINK:   st_n = S_JSR_JUMP;
            S_LD_ADDR:    st_n = S_LD_READ;
            S_LD_READ:    if (hold_last) st_n = S_LD_WB;
            S_ST_ADDR:    st_n = S_ST_DATA;
            S_ST_DATA:    st_n = S_ST_WRITE;
            S_ST_WRITE:   if (hold_last) st_n = S_FADDR;
            S_PAUSE_WAIT: if (cont) st_n = S_PAUSE_REL;
            S_PAUSE_REL:  if (!cont) st_n = S_FADDR;
            default:      st_n = S_FADDR;
        endcase
    end

endmodule

// File: rtl/seq_outdec.sv
module seq_outdec
    import seq_pkg::*;
(
    input  seq_state_e st,
    input  logic       hold_last,
    output ctl_t       ctl
);

    always_comb begin
        ctl = '0;
        unique case (st)
            S_FADDR: begin
                ctl.gate_pc = 1'b1;
                ctl.ld_mar  = 1'b1;
                ctl.ld_pc   = 1'b1;
                ctl.pc_sel  = PCS_INC;
            end
            S_FREAD, S_LD_READ: begin
                ctl.mem_en  = 1'b1;
                ctl.ld_mdr  = hold_last;
                ctl.mdr_src = hold_last;
            end
            S_FIR: begin
                ctl.gate_mdr = 1'b1;
                ctl.ld_ir    = 1'b1;
            end
            S_DECODE: ctl.ld_ben = 1'b1;
            S_ADD, S_AND, S_NOT: begin
                ctl.gate_alu = 1'b1;
                ctl.ld_reg   = 1'b1;
                ctl.ld_cc    = 1'b1;
                ctl.alu_op   = (st == S_ADD) ? ALU_ADD :
                               (st == S_AND) ? ALU_AND : ALU_NOT;
            end
            S_BRTAKE: begin
                ctl.ld_pc     = 1'b1;
                ctl.pc_sel    = PCS_ADDER;
                ctl.addr1_sel = A1_PC;
                ctl.addr2_sel = A2_OFF9;
            end
            S_JMP: begin
                ctl.ld_pc     = 1'b1;
                ctl.pc_sel    = PCS_ADDER;
                ctl.addr1_sel = A1_BASE;
                ctl.addr2_sel = A2_ZERO;
            end
            S_JSR_LINK: begin
                ctl.gate_pc = 1'b1;
                ctl.ld_reg  = 1'b1;
                ctl.dr_sel  = 1'b1;
            end
            S_JSR_JUMP: begin
                ctl.ld_pc     = 1'b1;
                ctl.pc_sel    = PCS_ADDER;
                ctl.addr1_sel = A1_PC;
                ctl.addr2_sel = A2_OFF11;
            end
            S_LD_ADDR, S_ST_ADDR: begin
                ctl.gate_addr = 1'b1;
                ctl.ld_mar    = 1'b1;
                ctl.addr1_sel = A1_BASE;
                ctl.addr2_sel = A2_OFF6;
            end
            S_LD_WB: begin
                ctl.gate_mdr = 1'b1;
                ctl.ld_reg   = 1'b1;
                ctl.ld_cc    = 1'b1;
            end
            S_ST_DATA: begin
                ctl.gate_alu = 1'b1;
                ctl.ld_mdr   = 1'b1;
                ctl.sr1_sel  = 1'b1;
                ctl.alu_op   = ALU_PASS;
            end
            S_ST_WRITE: begin
                ctl.mem_en = 1'b1;
                ctl.mem_we = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
    import seq_pkg::*;
#(
    parameter int MEM_HOLD = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  logic       cont_i,
    input  logic [3:0] opcode_i,
    input  logic       ben_i,
    output logic       gate_pc,
    output logic       gate_mdr,
    output logic       gate_alu,
    output logic       gate_addr,
    output logic       ld_mar,
    output logic       ld_mdr,
    output logic       ld_ir,
    output logic       ld_reg,
    output logic       ld_pc,
    output logic       ld_cc,
    output logic       ld_ben,
    output logic [1:0] pc_sel,
    output logic       addr1_sel,
    output logic [1:0] addr2_sel,
    output logic       dr_sel,
    output logic       sr1_sel,
    output logic [1:0] alu_op,
    output logic       mdr_src,
    output logic       mem_en,
    output logic       mem_we
);

    localparam int CNT_W = (MEM_HOLD > 0) ? $clog2(MEM_HOLD + 1) : 1;

    seq_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hold_last;
    ctl_t             ctl;

    seq_next #(.MEM_HOLD(MEM_HOLD), .CNT_W(CNT_W)) u_next (
        .st        (st_q),
        .cnt       (cnt_q),
        .opcode    (opcode_i),
        .ben       (ben_i),
        .run       (run_i),
        .cont      (cont_i),
        .st_n      (st_d),
        .cnt_n     (cnt_d),
        .hold_last (hold_last)
    );

    seq_outdec u_dec (
        .st        (st_q),
        .hold_last (hold_last),
        .ctl       (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_HALT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign gate_pc   = ctl.gate_pc;
    assign gate_mdr  = ctl.gate_mdr;
    assign gate_alu  = ctl.gate_alu;
    assign gate_addr = ctl.gate_addr;
    assign ld_mar    = ctl.ld_mar;
    assign ld_mdr    = ctl.ld_mdr;
    assign ld_ir     = ctl.ld_ir;
    assign ld_reg    = ctl.ld_reg;
    assign ld_pc     = ctl.ld_pc;
    assign ld_cc     = ctl.ld_cc;
    assign ld_ben    = ctl.ld_ben;
    assign pc_sel    = ctl.pc_sel;
    assign addr1_sel = ctl.addr1_sel;
    assign addr2_sel = ctl.addr2_sel;
    assign dr_sel    = ctl.dr_sel;
    assign sr1_sel   = ctl.sr1_sel;
    assign alu_op    = ctl.alu_op;
    assign mdr_src   = ctl.mdr_src;
    assign mem_en    = ctl.mem_en;
    assign mem_we    = ctl.mem_we;

    a_r3_one_gate: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gate_pc, gate_mdr, gate_alu, gate_addr}));

    a_r4_one_load: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_mar, ld_mdr, ld_ir, ld_reg}));

    a_r13_write_needs_enable: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_en);

    a_r1_halt_until_run: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_HALT && !run_i) |=> (st_q == S_HALT));

    a_r11_pause_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_PAUSE_WAIT && !cont_i) |=> (st_q == S_PAUSE_WAIT));

    a_r11_release_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_PAUSE_REL && cont_i) |=> (st_q == S_PAUSE_REL));

    a_r2_ir_after_mdr: assert property (@(posedge clk) disable iff (rst)
        ld_ir |-> $past(ld_mdr));

    a_r2_decode_after_ir: assert property (@(posedge clk) disable iff (rst)
        ld_ir |=> ld_ben);

endmodule

// File: tb/instr_sequencer_test.sv
`timescale 1ns/1ps
module instr_sequencer_test;

    localparam int MEM_HOLD = 2;
    localparam int WIDTH    = 23;

    logic clk = 1'b0;
    logic rst, run_i, cont_i, ben_i;
    logic [3:0] opcode_i;
    logic gate_pc, gate_mdr, gate_alu, gate_addr;
    logic ld_mar, ld_mdr, ld_ir, ld_reg, ld_pc, ld_cc, ld_ben;
    logic [1:0] pc_sel, addr2_sel, alu_op;
    logic addr1_sel, dr_sel, sr1_sel, mdr_src, mem_en, mem_we;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    instr_sequencer #(.MEM_HOLD(MEM_HOLD)) uut (
        .clk(clk), .rst(rst), .run_i(run_i), .cont_i(cont_i),
        .opcode_i(opcode_i), .ben_i(ben_i),
        .gate_pc(gate_pc), .gate_mdr(gate_mdr), .gate_alu(gate_alu),
        .gate_addr(gate_addr), .ld_mar(ld_mar), .ld_mdr(ld_mdr),
        .ld_ir(ld_ir), .ld_reg(ld_reg), .ld_pc(ld_pc), .ld_cc(ld_cc),
        .ld_ben(ld_ben), .pc_sel(pc_sel), .addr1_sel(addr1_sel),
        .addr2_sel(addr2_sel), .dr_sel(dr_sel), .sr1_sel(sr1_sel),
        .alu_op(alu_op), .mdr_src(mdr_src), .mem_en(mem_en), .mem_we(mem_we)
    );

    function automatic logic [WIDTH-1:0] cv(
        input logic [3:0] g, input logic [6:0] l, input logic [1:0] pcs,
        input logic a1, input logic [1:0] a2, input logic dr, input logic sr1,
        input logic [1:0] alu, input logic mdrs, input logic men, input logic mwe);
        return {g, l, pcs, a1, a2, dr, sr1, alu, mdrs, men, mwe};
    endfunction

    // gates {pc,mdr,alu,addr}; loads {mar,mdr,ir,reg,pc,cc,ben}
    localparam logic [WIDTH-1:0] V_IDLE  = '0;
    localparam logic [WIDTH-1:0] V_FADDR = cv(4'b1000, 7'b1000100, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    localparam logic [WIDTH-1:0] V_RDW   = cv(4'b0000, 7'b0000000, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
    localparam logic [WIDTH-1:0] V_RDL   = cv(4'b0000, 7'b0100000, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
    localparam logic [WIDTH-1:0] V_FIR   = cv(4'b0100, 7'b0010000, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    localparam logic [WIDTH-1:0] V_DEC   = cv(4'b0000, 7'b0000001, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    localparam logic [WIDTH-1:0] V_ADD   = cv(4'b0010, 7'b0001010, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    localparam logic [WIDTH-1:0] V_AND   = cv(4'b0010, 7'b0001010, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0);
    localparam logic [WIDTH-1:0] V_NOT   = cv(4'b0010, 7'b0001010, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0);
    localparam logic [WIDTH-1:0] V_BRT   = cv(4'b0000, 7'b0000100, 2'd2, 1'b0, 2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    localparam logic [WIDTH-1:0] V_JMP   = cv(4'b0000, 7'b0000100, 2'd2, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    localparam logic [WIDTH-1:0] V_JSR1  = cv(4'b1000, 7'b0001000, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    localparam logic [WIDTH-1:0] V_JSR2  = cv(4'b0000, 7'b0000100, 2'd2, 1'b0, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    localparam logic [WIDTH-1:0] V_MADR  = cv(4'b0001, 7'b1000000, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    localparam logic [WIDTH-1:0] V_LDWB  = cv(4'b0100, 7'b0001010, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    localparam logic [WIDTH-1:0] V_STD   = cv(4'b0010, 7'b0100000, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0);
    localparam logic [WIDTH-1:0] V_STW   = cv(4'b0000, 7'b0000000, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1);

    typedef struct {
        logic [WIDTH-1:0] v;
        string            tag;
    } item_t;
    item_t exp_q[$];

    wire [WIDTH-1:0] obs = {gate_pc, gate_mdr, gate_alu, gate_addr,
                            ld_mar, ld_mdr, ld_ir, ld_reg, ld_pc, ld_cc, ld_ben,
                            pc_sel, addr1_sel, addr2_sel, dr_sel, sr1_sel,
                            alu_op, mdr_src, mem_en, mem_we};

    // Monitor: compares the current cycle's outputs against the scoreboard head
    item_t cur;
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            n_run++;
            if (obs !== cur.v) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", cur.tag, obs, cur.v);
            end
        end
    end

    // Driver: one expected item per cycle, pushed just after the clock edge
    task automatic chk(input logic [WIDTH-1:0] v, input string tag);
        exp_q.push_back('{v: v, tag: tag});
        @(posedge clk);
        #1;
    endtask

    task automatic fetch(input logic [3:0] op);
        opcode_i = op;
        chk(V_FADDR, "R2 addr");
        repeat (MEM_HOLD) chk(V_RDW, "R2 wait");
        chk(V_RDL, "R2 read");
        chk(V_FIR, "R2 ir");
        chk(V_DEC, "R2 decode");
    endtask

    initial begin
        rst = 1'b1; run_i = 1'b0; cont_i = 1'b0; ben_i = 1'b0; opcode_i = 4'h0;
        @(posedge clk); #1;
        repeat (2) chk(V_IDLE, "R1 reset");
        rst = 1'b0;
        repeat (3) chk(V_IDLE, "R1 halted");
        run_i = 1'b1;
        chk(V_IDLE, "R1 run");
        run_i = 1'b0;

        fetch(4'b0001); chk(V_ADD, "R5 add");
        fetch(4'b0101); chk(V_AND, "R5 and");
        fetch(4'b1001); chk(V_NOT, "R5 not");

        ben_i = 1'b1;
        fetch(4'b0000); chk(V_IDLE, "R6 check"); chk(V_BRT, "R6 taken");
        ben_i = 1'b0;
        fetch(4'b0000); chk(V_IDLE, "R6 not taken");

        fetch(4'b1100); chk(V_JMP, "R7 jump");
        fetch(4'b0100); chk(V_JSR1, "R8 link"); chk(V_JSR2, "R8 jump");

        fetch(4'b0110);
        chk(V_MADR, "R9 addr");
        repeat (MEM_HOLD) chk(V_RDW, "R9 wait");
        chk(V_RDL, "R9 read");
        chk(V_LDWB, "R9 writeback");

        fetch(4'b0111);
        chk(V_MADR, "R10 addr");
        chk(V_STD, "R10 data");
        repeat (MEM_HOLD + 1) chk(V_STW, "R10 R13 write");

        // R12: unlisted opcode, next fetch address cycle follows decode directly
        fetch(4'b1111);
        fetch(4'b1000);

        // R11: press then release
        fetch(4'b1101);
        repeat (3) chk(V_IDLE, "R11 waiting");
        cont_i = 1'b1;
        chk(V_IDLE, "R11 pressed");
        repeat (2) chk(V_IDLE, "R11 held");
        cont_i = 1'b0;
        chk(V_IDLE, "R11 released");

        // R11: Continue already high when the pause is entered
        cont_i = 1'b1;
        fetch(4'b1101);
        chk(V_IDLE, "R11 early press");
        chk(V_IDLE, "R11 early held");
        cont_i = 1'b0;
        chk(V_IDLE, "R11 early released");

        // R1: reset during a fetch read, together with Run
        opcode_i = 4'b0001;
        chk(V_FADDR, "R2 addr");
        rst = 1'b1; run_i = 1'b1;
        chk(V_RDW, "R1 before reset");
        repeat (2) chk(V_IDLE, "R1 reset wins");
        rst = 1'b0; run_i = 1'b0;
        repeat (2) chk(V_IDLE, "R1 halted again");
        run_i = 1'b1;
        chk(V_IDLE, "R1 restart");
        run_i = 1'b0;
        fetch(4'b0001); chk(V_ADD, "R5 after restart");

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule